// File: doc/BRIEF.md
# DMA Request Handshake Controller

This block drives the request line to an external DMA engine and follows that engine's active-low acknowledge and its terminal-count signal. Software programs a control register and a count register, then writes the start register. After a fixed arming delay the request rises. From then on one of four disciplines governs it until the transfer terminates.

The first discipline is a cycle-steal handshake that gives up the bus after every transfer. The second is a demand burst that holds the request the whole time. The other two are refresh-friendly bursts. They cut a long burst once a limit is reached, counted either in prescaled clock ticks or in completed transfers. After the acknowledge clears, the request stays low until a retrigger comes. That retrigger is either an internal gate time of fixed minimum length or an external refresh-done pulse.

A 9-bit internal terminal count can end the cycle-steal and demand modes. It is loaded at start, decremented once per completed transfer and signalled by a one-cycle flag.

Top module: `dma_req_ctrl`

## Requirements
- R1: After reset `dreq` and `tc_int` are 0 and both registers hold 0, so the enable bit is clear.
- R2: A write to address 2 (start) while control bit 0 (enable) is 1 raises `dreq` exactly START_DLY (4) clock edges after the edge that captures the write. A start write while enable is 0 has no effect.
- R3: Mode field control[3:2] = 00 (cycle steal): `dreq` falls on the edge that samples `dack_n` low. It rises again on the edge that samples `dack_n` high. This repeats until termination.
- R4: Mode 01 (demand burst): `dreq` stays high while transfers are acknowledged and only drops on termination.
- R5: `tc_ext` sampled high ends any active transfer: `dreq` is 0 after that edge and stays 0 until a new start.
- R6: In modes 00/01 the start loads a 9-bit count {control[7], count register}, where 0 means 512. It decrements on every edge where `xfer_stb` is high with `dack_n` low. The transfer that brings it to zero makes `tc_int` high for exactly one cycle. That transfer also ends the request only when control bit 4 is 1.
- R7: Mode 10 (timer burst): while requesting with `dack_n` low, a tick occurs every TICK_DIV (4) edges. On the edge of the limit-th tick, `dreq` drops, where the limit is the count register and 0 means 256.
- R8: Mode 11 (cycle burst): `dreq` drops on the edge that samples the limit-th `xfer_stb` of the burst, again with 0 meaning 256.
- R9: With control bit 5 = 1 (internal retrigger), after a burst cut `dreq` stays low for G cycles after the edge that samples `dack_n` high and then rises. G = ceil(ns x CLK_KHZ / 10^6), with ns = 350 when control bit 6 = 0 and 750 when it is 1. That gives 18 and 38 cycles at 50 MHz.
- R10: With control bit 5 = 0 (external retrigger), after a cut and `dack_n` high, `dreq` waits for `rtrg_ext` and rises on the edge that samples it. If control bit 6 = 1 in this setting, the first request after start also waits for `rtrg_ext`.
- R11: Writing the control register with bit 0 = 0 forces `dreq` and `tc_int` low after that edge and clears all counters. Re-enabling does not restart the transfer, and the next start reloads the terminal count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | AW | Register address: 0 control, 1 count, 2 start |
| reg_wdata | input | 8 | Register write data |
| dack_n | input | 1 | DMA acknowledge, active low |
| tc_ext | input | 1 | External terminal count, active high |
| xfer_stb | input | 1 | One pulse per completed bus transfer |
| rtrg_ext | input | 1 | External retrigger (refresh done) pulse |
| dreq | output | 1 | DMA request |
| tc_int | output | 1 | Internal terminal count reached, one-cycle pulse |

## Verification
The bound checker watches several rules on every cycle. The request always falls after an acknowledge in cycle-steal mode and always holds in demand mode. External TC or a disable always clears it. A burst-limit event always cuts it, and an expired gate timer always restores it. The terminal-count flag never lasts longer than one cycle. Only the bench scenarios can show the exact arming delay, the 9-bit count with its top bit and the lengths of the two gate windows. The same holds for the timer-tick spacing, waiting on an external refresh and the reload of the count after a disable.

// File: rtl/dma_req_pkg.sv
package dma_req_pkg;

  localparam int REG_W = 8;
  localparam int TC_W  = 9;

  typedef enum logic [1:0] {
    MODE_SINGLE   = 2'b00,
    MODE_DEMAND   = 2'b01,
    MODE_PB_TIMER = 2'b10,
    MODE_PB_CYCLE = 2'b11
  } xfer_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARM,
    ST_REQ,
    ST_ACKWAIT,
    ST_HOLD,
    ST_GATE,
    ST_RTWAIT
  } req_state_e;

  // Control register image; bit 1 of the written byte is not stored.
  typedef struct packed {
    logic       tc_msb;     // bit 7
    logic       gate_sel;   // bit 6: long gate / wait-for-refresh start
    logic       rtrg_int;   // bit 5: 1 internal retrigger
    logic       tc_int_en;  // bit 4: internal TC may end the transfer
    xfer_mode_e mode;       // bits 3:2
    logic       en;         // bit 0
  } bus_ctrl_t;

  localparam int ADDR_CTRL  = 0;
  localparam int ADDR_COUNT = 1;
  localparam int ADDR_START = 2;

  // Minimum time in ns to clock cycles, rounded up, never below one.
  function automatic int gate_cycles(int ns, int clk_khz);
    longint p;
    longint c;
    p = longint'(ns) * longint'(clk_khz);
    c = (p + 64'd999999) / 64'd1000000;
    if (c < 1) c = 1;
    return int'(c);
  endfunction

  function automatic logic is_pburst(xfer_mode_e m);
    return m[1];
  endfunction

  function automatic logic [TC_W-1:0] tc_load_value(logic msb, logic [REG_W-1:0] lo);
    return {msb, lo};
  endfunction

endpackage

// File: rtl/dma_cfg_regs.sv
module dma_cfg_regs
  import dma_req_pkg::*;
#(
  parameter int AW = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [AW-1:0]    addr,
  input  logic [REG_W-1:0] wdata,
  output bus_ctrl_t        ctrl,
  output logic [REG_W-1:0] count,
  output logic             start_evt,
  output logic             stop_evt
);

  localparam logic [AW-1:0] A_CTRL  = AW'(ADDR_CTRL);
  localparam logic [AW-1:0] A_COUNT = AW'(ADDR_COUNT);
  localparam logic [AW-1:0] A_START = AW'(ADDR_START);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl  <= '0;
      count <= '0;
    end else if (wr) begin
      if (addr == A_CTRL) begin
        ctrl <= bus_ctrl_t'({wdata[7:2], wdata[0]});
      end
      if (addr == A_COUNT) begin
        count <= wdata;
      end
    end
  end

  assign start_evt = wr && (addr == A_START) && ctrl.en;
  assign stop_evt  = wr && (addr == A_CTRL) && !wdata[0];

endmodule

// File: rtl/dma_tc_counter.sv
module dma_tc_counter #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         hit
);

  logic [W-1:0] cnt;

  // A loaded zero wraps through all 2**W values before reaching one.
  assign hit = dec && !load && (cnt == W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clr) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (dec) begin
      cnt <= cnt - W'(1);
    end
  end

endmodule

// File: rtl/dma_run_limiter.sv
module dma_run_limiter #(
  parameter int TICK_DIV = 4,
  parameter int LW       = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          active,
  input  logic          use_timer,
  input  logic          xfer,
  input  logic [LW-1:0] limit,
  output logic          hit
);

  localparam int TW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  logic [TW-1:0] tcnt;
  logic [LW-1:0] run;
  logic          tick;
  logic          step;

  assign tick = active && (tcnt == TW'(TICK_DIV - 1));
  assign step = use_timer ? tick : (active && xfer);
  assign hit  = step && (LW'(run + 1'b1) == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcnt <= '0;
      run  <= '0;
    end else if (clr) begin
      tcnt <= '0;
      run  <= '0;
    end else begin
      if (active) begin
        tcnt <= tick ? '0 : tcnt + TW'(1);
      end
      if (step) begin
        run <= run + LW'(1);
      end
    end
  end

endmodule

// File: rtl/dma_gate_timer.sv
module dma_gate_timer #(
  parameter int SHORT_CYC = 18,
  parameter int LONG_CYC  = 38
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic load,
  input  logic long_sel,
  output logic done
);

  localparam int MAXC = (LONG_CYC > SHORT_CYC) ? LONG_CYC : SHORT_CYC;
  localparam int GW   = $clog2(MAXC + 1);

  logic [GW-1:0] cnt;
  logic          running;

  assign done = running && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      running <= 1'b0;
    end else if (clr) begin
      cnt     <= '0;
      running <= 1'b0;
    end else if (load) begin
      cnt     <= long_sel ? GW'(LONG_CYC - 1) : GW'(SHORT_CYC - 1);
      running <= 1'b1;
    end else if (running) begin
      if (cnt == '0) running <= 1'b0;
      else           cnt     <= cnt - GW'(1);
    end
  end

endmodule

// File: rtl/dma_req_ctrl.sv
module dma_req_ctrl
  import dma_req_pkg::*;
#(
  parameter int CLK_KHZ   = 50000,
  parameter int START_DLY = 4,
  parameter int TICK_DIV  = 4,
  parameter int SHORT_NS  = 350,
  parameter int LONG_NS   = 750,
  parameter int AW        = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [AW-1:0]    reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  input  logic             dack_n,
  input  logic             tc_ext,
  input  logic             xfer_stb,
  input  logic             rtrg_ext,
  output logic             dreq,
  output logic             tc_int
);

  localparam int SHORT_CYC = gate_cycles(SHORT_NS, CLK_KHZ);
  localparam int LONG_CYC  = gate_cycles(LONG_NS, CLK_KHZ);
  localparam int DLW       = (START_DLY > 1) ? $clog2(START_DLY) : 1;

  bus_ctrl_t        ctrl_q;
  logic [REG_W-1:0] count_q;
  logic             start_evt;
  logic             stop_evt;
  req_state_e       st, st_nx;
  logic [DLW-1:0]   dly;
  xfer_mode_e       cur_mode;
  logic             pburst;
  logic             active;
  logic             tc_dec;
  logic             tc_hit;
  logic             tc_end_int;
  logic             limit_hit;
  logic             gate_done;
  logic             gate_load;
  logic             tc_int_q;

  dma_cfg_regs #(.AW(AW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr        (reg_wr),
    .addr      (reg_addr),
    .wdata     (reg_wdata),
    .ctrl      (ctrl_q),
    .count     (count_q),
    .start_evt (start_evt),
    .stop_evt  (stop_evt)
  );

  assign cur_mode = ctrl_q.mode;
  assign pburst   = is_pburst(cur_mode);
  assign active   = (st != ST_IDLE) && (st != ST_ARM);

  // Internal terminal count: modes 00 and 01 only.
  assign tc_dec = active && !pburst && !dack_n && xfer_stb;

  dma_tc_counter #(.W(TC_W)) u_tc (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (stop_evt),
    .load     (start_evt),
    .load_val (tc_load_value(ctrl_q.tc_msb, count_q)),
    .dec      (tc_dec),
    .hit      (tc_hit)
  );

  assign tc_end_int = tc_hit && ctrl_q.tc_int_en;

  dma_run_limiter #(.TICK_DIV(TICK_DIV), .LW(REG_W)) u_run (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (st != ST_REQ),
    .active    ((st == ST_REQ) && !dack_n && pburst),
    .use_timer (cur_mode == MODE_PB_TIMER),
    .xfer      (xfer_stb),
    .limit     (count_q),
    .hit       (limit_hit)
  );

  assign gate_load = (st == ST_HOLD) && (st_nx == ST_GATE);

  dma_gate_timer #(.SHORT_CYC(SHORT_CYC), .LONG_CYC(LONG_CYC)) u_gate (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (st_nx == ST_IDLE),
    .load     (gate_load),
    .long_sel (ctrl_q.gate_sel),
    .done     (gate_done)
  );

  always_comb begin
    st_nx = st;
    if (stop_evt) begin
      st_nx = ST_IDLE;
    end else if (start_evt) begin
      st_nx = ST_ARM;
    end else if (st != ST_IDLE && (!ctrl_q.en || tc_ext || tc_end_int)) begin
      st_nx = ST_IDLE;
    end else begin
      unique case (st)
        ST_ARM: begin
          if (dly == '0) begin
            st_nx = (pburst && !ctrl_q.rtrg_int && ctrl_q.gate_sel) ? ST_RTWAIT : ST_REQ;
          end
        end
        ST_REQ: begin
          if (cur_mode == MODE_SINGLE && !dack_n) st_nx = ST_ACKWAIT;
          else if (pburst && limit_hit)           st_nx = ST_HOLD;
        end
        ST_ACKWAIT: if (dack_n) st_nx = ST_REQ;
        ST_HOLD: begin
          if (dack_n) st_nx = ctrl_q.rtrg_int ? ST_GATE : ST_RTWAIT;
        end
        ST_GATE:   if (gate_done) st_nx = ST_REQ;
        ST_RTWAIT: if (rtrg_ext)  st_nx = ST_REQ;
        default:   st_nx = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      dly      <= '0;
      tc_int_q <= 1'b0;
    end else begin
      st       <= st_nx;
      tc_int_q <= stop_evt ? 1'b0 : tc_hit;
      if (start_evt) begin
        dly <= DLW'(START_DLY - 1);
      end else if (st == ST_ARM && dly != '0) begin
        dly <= dly - DLW'(1);
      end
    end
  end

  assign dreq   = (st == ST_REQ);
  assign tc_int = tc_int_q;

endmodule

// File: rtl/dma_req_ctrl_chk.sv
module dma_req_ctrl_chk
  import dma_req_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       reg_wr,
  input logic       dack_n,
  input logic       tc_ext,
  input logic       dreq,
  input logic       tc_int,
  input xfer_mode_e cur_mode,
  input logic       tc_end_int,
  input logic       limit_hit,
  input logic       gate_done,
  input logic       stop_evt
);

  // R3: cycle steal gives up the request once acknowledged
  a_r3_single_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_mode == MODE_SINGLE && dreq && !dack_n && !reg_wr) |=> !dreq);

  // R4: demand burst keeps the request until a termination
  a_r4_demand_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_mode == MODE_DEMAND && dreq && !reg_wr && !tc_ext && !tc_end_int) |=> dreq);

  // R5: external terminal count always ends the request
  a_r5_ext_tc_stop: assert property (@(posedge clk) disable iff (!rst_n)
    tc_ext |=> !dreq);

  // R6: internal terminal count flag is a single-cycle pulse
  a_r6_tc_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    tc_int |=> !tc_int);

  // R7 and R8: a reached burst limit cuts the request
  a_r8_limit_cut: assert property (@(posedge clk) disable iff (!rst_n)
    (limit_hit && !reg_wr) |=> !dreq);

  // R9: an expired gate window restores the request
  a_r9_gate_resume: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_done && !reg_wr && !tc_ext) |=> dreq);

  // R11: disabling forces both outputs low
  a_r11_disable: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> (!dreq && !tc_int));

endmodule

bind dma_req_ctrl dma_req_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_wr     (reg_wr),
  .dack_n     (dack_n),
  .tc_ext     (tc_ext),
  .dreq       (dreq),
  .tc_int     (tc_int),
  .cur_mode   (cur_mode),
  .tc_end_int (tc_end_int),
  .limit_hit  (limit_hit),
  .gate_done  (gate_done),
  .stop_evt   (stop_evt)
);

// File: tb/tb_dma_req_ctrl.sv
`timescale 1ns/1ps
module tb_dma_req_ctrl;

  localparam int CLK_KHZ = 50000;
  localparam int GATE_S  = (350 * (CLK_KHZ / 1000) + 999) / 1000;
  localparam int GATE_L  = (750 * (CLK_KHZ / 1000) + 999) / 1000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       reg_wr;
  logic [1:0] reg_addr;
  logic [7:0] reg_wdata;
  logic       dack_n, tc_ext, xfer_stb, rtrg_ext;
  logic       dreq, tc_int;

  always #10 clk = ~clk;

  dma_req_ctrl dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .dack_n(dack_n), .tc_ext(tc_ext),
    .xfer_stb(xfer_stb), .rtrg_ext(rtrg_ext), .dreq(dreq), .tc_int(tc_int)
  );

  typedef struct {
    int    at;
    logic  dreq;
    logic  tci;
    string tag;
  } exp_t;

  exp_t q[$];
  exp_t cur;
  int   cyc    = 0;
  int   n_cmp  = 0;
  int   n_bad  = 0;
  bit   done   = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: compare due expectations away from the active edge.
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].at <= cyc) begin
      cur = q.pop_front();
      n_cmp++;
      if (cur.at < cyc || dreq !== cur.dreq || tc_int !== cur.tci) begin
        n_bad++;
        $display("FAIL %s @%0d: dreq=%b tc_int=%b expected dreq=%b tc_int=%b",
                 cur.tag, cyc, dreq, tc_int, cur.dreq, cur.tci);
      end
    end
  end

  task automatic expect_at(int off, logic d, logic t, string tag);
    exp_t e;
    e.at = cyc + off; e.dreq = d; e.tci = t; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic nclk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic pulse_xfer();
    xfer_stb = 1'b1;
    @(negedge clk);
    xfer_stb = 1'b0;
  endtask

  task automatic stop_ext();
    tc_ext = 1'b1;
    expect_at(1, 1'b0, 1'b0, "R5 external tc stop");
    @(negedge clk);
    tc_ext = 1'b0;
    dack_n = 1'b1;
    nclk(2);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    dack_n = 1'b1; tc_ext = 1'b0; xfer_stb = 1'b0; rtrg_ext = 1'b0;
    nclk(3);
    rst_n = 1'b1;
    expect_at(1, 1'b0, 1'b0, "R1 reset outputs");
    nclk(2);

    // R2: start ignored while disabled (registers reset to zero)
    wr(2'd2, 8'h00);
    expect_at(4, 1'b0, 1'b0, "R2 start ignored when disabled");
    expect_at(6, 1'b0, 1'b0, "R2 start ignored when disabled");
    nclk(6);

    // R2/R3: cycle steal, ctrl = enable, mode 00
    wr(2'd0, 8'h01);
    wr(2'd1, 8'h05);
    wr(2'd2, 8'h00);
    expect_at(3, 1'b0, 1'b0, "R2 still arming");
    expect_at(4, 1'b1, 1'b0, "R2 request after delay");
    nclk(4);
    dack_n = 1'b0;
    expect_at(1, 1'b0, 1'b0, "R3 drop on ack");
    nclk(1);
    dack_n = 1'b1;
    expect_at(1, 1'b1, 1'b0, "R3 reassert on ack release");
    nclk(2);
    dack_n = 1'b0;
    expect_at(1, 1'b0, 1'b0, "R3 second handshake drop");
    nclk(1);
    dack_n = 1'b1;
    expect_at(1, 1'b1, 1'b0, "R3 second handshake reassert");
    nclk(1);
    stop_ext();
    expect_at(3, 1'b0, 1'b0, "R5 stays idle after tc");
    nclk(3);

    // R4/R6: demand burst, internal TC enabled, count 3
    wr(2'd0, 8'h15);
    wr(2'd1, 8'h03);
    wr(2'd2, 8'h00);
    expect_at(4, 1'b1, 1'b0, "R4 burst request");
    nclk(4);
    dack_n = 1'b0;
    expect_at(3, 1'b1, 1'b0, "R4 held during ack");
    nclk(3);
    pulse_xfer();
    pulse_xfer();
    expect_at(1, 1'b1, 1'b0, "R6 two of three transfers");
    nclk(1);
    expect_at(1, 1'b0, 1'b1, "R6 internal tc ends burst");
    expect_at(2, 1'b0, 1'b0, "R6 tc pulse one cycle");
    pulse_xfer();
    nclk(2);
    dack_n = 1'b1;
    nclk(2);

    // R6: ninth count bit, internal TC not allowed to stop: 258 transfers
    wr(2'd0, 8'h85);
    wr(2'd1, 8'h02);
    wr(2'd2, 8'h00);
    nclk(4);
    dack_n = 1'b0;
    xfer_stb = 1'b1;
    expect_at(257, 1'b1, 1'b0, "R6 ninth bit not yet zero");
    expect_at(258, 1'b1, 1'b1, "R6 tc flag without stop");
    expect_at(259, 1'b1, 1'b0, "R6 tc flag clears");
    nclk(258);
    xfer_stb = 1'b0;
    nclk(1);
    stop_ext();

    // R8/R9: cycle burst, internal retrigger, short gate, limit 3
    wr(2'd0, 8'h2D);
    wr(2'd1, 8'h03);
    wr(2'd2, 8'h00);
    nclk(4);
    dack_n = 1'b0;
    xfer_stb = 1'b1;
    expect_at(2, 1'b1, 1'b0, "R8 below cycle limit");
    expect_at(3, 1'b0, 1'b0, "R8 cycle limit cuts request");
    nclk(3);
    xfer_stb = 1'b0;
    nclk(1);
    dack_n = 1'b1;
    expect_at(GATE_S, 1'b0, 1'b0, "R9 short gate still low");
    expect_at(GATE_S + 1, 1'b1, 1'b0, "R9 short gate ends");
    nclk(GATE_S + 1);
    stop_ext();

    // R9: long gate
    wr(2'd0, 8'h6D);
    wr(2'd2, 8'h00);
    nclk(4);
    dack_n = 1'b0;
    xfer_stb = 1'b1;
    expect_at(3, 1'b0, 1'b0, "R8 cycle limit cuts request");
    nclk(3);
    xfer_stb = 1'b0;
    nclk(1);
    dack_n = 1'b1;
    expect_at(GATE_L, 1'b0, 1'b0, "R9 long gate still low");
    expect_at(GATE_L + 1, 1'b1, 1'b0, "R9 long gate ends");
    nclk(GATE_L + 1);
    stop_ext();

    // R7/R10: timer burst, external retrigger, limit 2 ticks
    wr(2'd0, 8'h09);
    wr(2'd1, 8'h02);
    wr(2'd2, 8'h00);
    nclk(4);
    dack_n = 1'b0;
    expect_at(7, 1'b1, 1'b0, "R7 before second tick");
    expect_at(8, 1'b0, 1'b0, "R7 cut after limit ticks");
    nclk(9);
    dack_n = 1'b1;
    expect_at(10, 1'b0, 1'b0, "R10 waits for retrigger");
    nclk(10);
    rtrg_ext = 1'b1;
    expect_at(1, 1'b1, 1'b0, "R10 retrigger restores request");
    nclk(1);
    rtrg_ext = 1'b0;
    stop_ext();

    // R10: start synchronised to refresh
    wr(2'd0, 8'h49);
    wr(2'd2, 8'h00);
    expect_at(6, 1'b0, 1'b0, "R10 start waits for refresh");
    nclk(6);
    rtrg_ext = 1'b1;
    expect_at(1, 1'b1, 1'b0, "R10 start after refresh");
    nclk(1);
    rtrg_ext = 1'b0;
    stop_ext();

    // R11: disable mid-burst, re-enable, restart reloads the count
    wr(2'd0, 8'h15);
    wr(2'd1, 8'h03);
    wr(2'd2, 8'h00);
    nclk(4);
    dack_n = 1'b0;
    pulse_xfer();
    expect_at(1, 1'b0, 1'b0, "R11 disable drops request");
    wr(2'd0, 8'h14);
    wr(2'd0, 8'h15);
    expect_at(3, 1'b0, 1'b0, "R11 re-enable does not restart");
    nclk(3);
    wr(2'd2, 8'h00);
    expect_at(4, 1'b1, 1'b0, "R11 restart requests");
    nclk(4);
    pulse_xfer();
    pulse_xfer();
    expect_at(1, 1'b1, 1'b0, "R11 count reloaded, two done");
    nclk(1);
    expect_at(1, 1'b0, 1'b1, "R11 fresh count ends on third");
    pulse_xfer();
    nclk(2);
    dack_n = 1'b1;
    nclk(3);

    done = 1'b1;
    if (q.size() != 0) begin
      n_bad += q.size();
      $display("FAIL scoreboard: %0d expectations unconsumed, expected 0", q.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule